// File: doc/BRIEF.md
# Dual Virtual Channel Link Endpoint

This block terminates one end of a point-to-point link that carries two independent virtual channels (VCs) over a 9-bit symbol bus with a forwarded clock. The forwarded clock runs at half the core clock. One symbol travels while it is low and a second while it is high, so every forwarded-clock period carries one 18-bit frame. A frame is either a 16-bit data word or a command token. On the transmit side the block merges two VC source streams and the credit returns owed to the far end onto that bus. On the receive side it reassembles frames and rejects malformed ones. Each accepted data word goes into a per-channel receive queue.

Flow control is credit based. The transmitter holds one counter per VC that starts at the depth of the remote receive queue. It spends one credit per data word and gets one back for every credit-return token it receives. Each word drained from a local receive queue schedules one credit-return token for that VC. The frame code keeps all valid frames at even parity and keeps the token codes apart from one another. As a result, a single flipped bit in a data frame never decodes as a token, and a single flipped bit in a token never decodes as another token.

Top module: `dvl_link`

## Requirements
- R1: While reset is held, the link shows the first symbol of an idle frame (9'h13C) with the forwarded clock low. src_ready, snk_valid and rx_err are all low.
- R2: The forwarded clock toggles every core cycle. Frame bits 17:9 travel while it is low and bits 8:0 while it is high. The receiver decodes a frame in the cycle its second symbol is present.
- R3: A data frame for word d is {0, d[15:8], XOR of all bits of d, d[7:0]}, so its 18 bits have even parity.
- R4: A token frame for 8-bit code c is {1, c, 1, ~c}. The codes are 3C (idle), 5A (select VC0), A5 (select VC1), 96 (credit VC0) and 69 (credit VC1).
- R5: Any received frame other than an even-parity data frame or one of the five token frames pulses rx_err for one cycle. Such a frame writes no data, returns no credit and leaves the selected channel unchanged. This covers every single-bit corruption of any valid frame.
- R6: Received data goes to the channel named by the most recent select token. The transmitter sends a select token before data whenever the channel changes.
- R7: The transmitter sends a data word on a VC only while it holds credit for that VC. With the remote queue drained by no one, exactly DEPTH words are accepted on that VC.
- R8: Each word taken from a receive queue causes one credit-return token for that VC. Credit tokens take priority over data, and each restores one transmit credit.
- R9: Each VC delivers its words in order. A VC whose sink is stalled does not hold up the other VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid | input | 2 | Word offered on VC v (bit v) |
| src_data | input | 32 | Words offered; VC v at bits 16v+15:16v |
| src_ready | output | 2 | Word on VC v taken this cycle |
| snk_valid | output | 2 | Receive queue of VC v not empty |
| snk_data | output | 32 | Head word of each receive queue |
| snk_ready | input | 2 | Consumer takes the head word of VC v |
| lnk_tx_clk | output | 1 | Forwarded clock, outgoing |
| lnk_tx_sym | output | 9 | Outgoing symbol |
| lnk_rx_clk | input | 1 | Forwarded clock, incoming |
| lnk_rx_sym | input | 9 | Incoming symbol |
| rx_err | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The assertions assume that the far end respects the credits this block returns, so a receive queue is never pushed while full. They also assume it never returns more credit than it was given, and that the incoming forwarded clock alternates with a symbol pair per period. The bench loops the link back on itself for all credit and channel traffic, which satisfies these assumptions by construction. In the corruption phase it drives the receive pins directly. It starts on a frame boundary, flips bits only in data, idle, select and credit frames, and injects valid data only into empty queues. It never injects a valid credit token.

// File: rtl/dvl_pkg.sv
package dvl_pkg;
  localparam int SYM_W  = 9;
  localparam int FRM_W  = 2 * SYM_W;
  localparam int WORD_W = 16;
  localparam int NUM_VC = 2;

  localparam logic [7:0] TK_IDLE = 8'h3C;
  localparam logic [7:0] TK_SEL0 = 8'h5A;
  localparam logic [7:0] TK_SEL1 = 8'hA5;
  localparam logic [7:0] TK_CRD0 = 8'h96;
  localparam logic [7:0] TK_CRD1 = 8'h69;

  // token frame: marker, code, pad, inverted code -> even parity, distance >= 8 apart
  function automatic logic [FRM_W-1:0] tok_frame(input logic [7:0] code);
    return {1'b1, code, 1'b1, ~code};
  endfunction

  // data frame: marker, high byte, word parity, low byte -> even parity
  function automatic logic [FRM_W-1:0] dat_frame(input logic [WORD_W-1:0] w);
    return {1'b0, w[15:8], ^w, w[7:0]};
  endfunction

  localparam logic [FRM_W-1:0] FR_IDLE = {1'b1, TK_IDLE, 1'b1, ~TK_IDLE};
  localparam logic [FRM_W-1:0] FR_SEL0 = {1'b1, TK_SEL0, 1'b1, ~TK_SEL0};
  localparam logic [FRM_W-1:0] FR_SEL1 = {1'b1, TK_SEL1, 1'b1, ~TK_SEL1};
  localparam logic [FRM_W-1:0] FR_CRD0 = {1'b1, TK_CRD0, 1'b1, ~TK_CRD0};
  localparam logic [FRM_W-1:0] FR_CRD1 = {1'b1, TK_CRD1, 1'b1, ~TK_CRD1};
endpackage

// File: rtl/dvl_fifo.sv
module dvl_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] dout,
  output logic         pop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_nx, rptr_q, rptr_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  assign rd_valid = (cnt_q != '0);
  assign pop      = rd_valid && rd_ready;
  assign dout     = mem[rptr_q];

  always_comb begin
    wptr_nx = wptr_q;
    rptr_nx = rptr_q;
    if (push) wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_nx = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    cnt_nx = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_nx;
      rptr_q <= rptr_nx;
      cnt_q  <= cnt_nx;
    end
  end

  // R7: the far transmitter's credit must keep this queue from overflowing
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
endmodule

// File: rtl/dvl_tx.sv
module dvl_tx
  import dvl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        src_valid,
  input  logic [NUM_VC*WORD_W-1:0] src_data,
  output logic [NUM_VC-1:0]        src_ready,
  input  logic [NUM_VC-1:0]        ret_req,
  input  logic [NUM_VC-1:0]        crd_in,
  output logic                     tx_clk,
  output logic [SYM_W-1:0]         tx_sym
);
  logic             ph_q;
  logic [FRM_W-1:0] frm_q, frm_nx;
  logic             cur_q, cur_nx, rr_q, rr_nx;
  logic [CW-1:0]    cred_q [NUM_VC];
  logic [CW-1:0]    cred_nx[NUM_VC];
  logic [CW-1:0]    pend_q [NUM_VC];
  logic [CW-1:0]    pend_nx[NUM_VC];
  logic [NUM_VC-1:0] elig, take, crd_sent;
  logic             pick;

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) elig[v] = src_valid[v] && (cred_q[v] != '0);
    frm_nx   = FR_IDLE;
    cur_nx   = cur_q;
    rr_nx    = rr_q;
    take     = '0;
    crd_sent = '0;
    pick     = 1'b0;
    if (pend_q[0] != '0) begin
      frm_nx      = FR_CRD0;
      crd_sent[0] = 1'b1;
    end else if (pend_q[1] != '0) begin
      frm_nx      = FR_CRD1;
      crd_sent[1] = 1'b1;
    end else if (|elig) begin
      pick = (elig[0] && elig[1]) ? rr_q : elig[1];
      if (pick != cur_q) begin
        frm_nx = pick ? FR_SEL1 : FR_SEL0;
        cur_nx = pick;
      end else begin
        frm_nx     = dat_frame(src_data[int'(pick)*WORD_W +: WORD_W]);
        take[pick] = 1'b1;
        rr_nx      = ~pick;
      end
    end
    // a new frame is chosen only in the last cycle of the current one
    if (!ph_q) begin
      frm_nx   = frm_q;
      cur_nx   = cur_q;
      rr_nx    = rr_q;
      take     = '0;
      crd_sent = '0;
    end
    for (int v = 0; v < NUM_VC; v++) begin
      cred_nx[v] = cred_q[v] - CW'(take[v]) + CW'(crd_in[v]);
      pend_nx[v] = pend_q[v] + CW'(ret_req[v]) - CW'(crd_sent[v]);
    end
  end

  assign src_ready = take;
  assign tx_clk    = ph_q;
  assign tx_sym    = ph_q ? frm_q[SYM_W-1:0] : frm_q[FRM_W-1:SYM_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      frm_q <= FR_IDLE;
      cur_q <= 1'b0;
      rr_q  <= 1'b0;
      for (int v = 0; v < NUM_VC; v++) begin
        cred_q[v] <= CW'(DEPTH);
        pend_q[v] <= '0;
      end
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        frm_q <= frm_nx;
        cur_q <= cur_nx;
        rr_q  <= rr_nx;
      end
      for (int v = 0; v < NUM_VC; v++) begin
        cred_q[v] <= cred_nx[v];
        pend_q[v] <= pend_nx[v];
      end
    end
  end

  // R2: the forwarded clock alternates every core cycle
  p_fclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_clk != $past(tx_clk)));

  for (genvar g = 0; g < NUM_VC; g++) begin : g_chk
    // R8: returned credit never exceeds what was granted
    p_credit_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cred_q[g] <= CW'(DEPTH));
    // R8: credits owed back never exceed the queue depth
    p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] <= CW'(DEPTH));
  end
endmodule

// File: rtl/dvl_rx.sv
module dvl_rx
  import dvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_clk,
  input  logic [SYM_W-1:0]  rx_sym,
  output logic              wr_vld,
  output logic              wr_vc,
  output logic [WORD_W-1:0] wr_data,
  output logic [NUM_VC-1:0] crd_ret,
  output logic              err
);
  logic [SYM_W-1:0]  hold_q;
  logic [FRM_W-1:0]  frame;
  logic              cur_q, cur_nx;
  logic              wr_vld_q, wr_vld_nx, err_q, err_nx;
  logic [WORD_W-1:0] wr_data_q, wr_data_nx;
  logic [NUM_VC-1:0] crd_q, crd_nx;

  assign frame = {hold_q, rx_sym};

  always_comb begin
    cur_nx     = cur_q;
    wr_vld_nx  = 1'b0;
    wr_data_nx = wr_data_q;
    crd_nx     = '0;
    err_nx     = 1'b0;
    if (rx_clk) begin
      if (!frame[FRM_W-1]) begin
        if (^frame) err_nx = 1'b1;
        else begin
          wr_vld_nx  = 1'b1;
          wr_data_nx = {frame[16:9], frame[7:0]};
        end
      end else begin
        case (frame)
          FR_IDLE: ;
          FR_SEL0: cur_nx = 1'b0;
          FR_SEL1: cur_nx = 1'b1;
          FR_CRD0: crd_nx[0] = 1'b1;
          FR_CRD1: crd_nx[1] = 1'b1;
          default: err_nx = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= FR_IDLE[FRM_W-1:SYM_W];
      cur_q     <= 1'b0;
      wr_vld_q  <= 1'b0;
      wr_data_q <= '0;
      crd_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (!rx_clk) hold_q <= rx_sym;
      if (rx_clk) cur_q <= cur_nx;
      wr_vld_q  <= wr_vld_nx;
      wr_data_q <= wr_data_nx;
      crd_q     <= crd_nx;
      err_q     <= err_nx;
    end
  end

  assign wr_vld  = wr_vld_q;
  assign wr_vc   = cur_q;
  assign wr_data = wr_data_q;
  assign crd_ret = crd_q;
  assign err     = err_q;

  // R5: a rejected frame has no side effect
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!wr_vld_q && (crd_q == '0) && (cur_q == $past(cur_q))));
  // R2: frames complete only in the high half of the forwarded clock
  p_decode_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_q || err_q || (crd_q != '0)) |-> $past(rx_clk));
endmodule

// File: rtl/dvl_link.sv
module dvl_link
  import dvl_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  src_valid,
  input  logic [31:0] src_data,
  output logic [1:0]  src_ready,
  output logic [1:0]  snk_valid,
  output logic [31:0] snk_data,
  input  logic [1:0]  snk_ready,
  output logic        lnk_tx_clk,
  output logic [8:0]  lnk_tx_sym,
  input  logic        lnk_rx_clk,
  input  logic [8:0]  lnk_rx_sym,
  output logic        rx_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              wr_vld, wr_vc;
  logic [WORD_W-1:0] wr_data;
  logic [NUM_VC-1:0] crd_ret, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  dvl_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n_i),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .ret_req(pop), .crd_in(crd_ret),
    .tx_clk(lnk_tx_clk), .tx_sym(lnk_tx_sym)
  );

  dvl_rx u_rx (
    .clk(clk), .rst_n(rst_n_i),
    .rx_clk(lnk_rx_clk), .rx_sym(lnk_rx_sym),
    .wr_vld(wr_vld), .wr_vc(wr_vc), .wr_data(wr_data),
    .crd_ret(crd_ret), .err(rx_err)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    dvl_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_q (
      .clk(clk), .rst_n(rst_n_i),
      .push(wr_vld && (wr_vc == v[0])), .din(wr_data),
      .rd_ready(snk_ready[v]), .rd_valid(snk_valid[v]),
      .dout(snk_data[v*WORD_W +: WORD_W]), .pop(pop[v])
    );
  end
endmodule

// File: tb/tb_dvl_link.sv
module tb_dvl_link;
  localparam int PER   = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_valid, src_ready, snk_valid, snk_ready;
  logic [31:0] src_data, snk_data;
  logic        lnk_tx_clk, rx_err;
  logic [8:0]  lnk_tx_sym;
  logic        inj, b_clk;
  logic [8:0]  b_sym;

  int n_chk = 0, n_bad = 0;
  int sent[2], tgt[2], rcv[2];
  int err_cnt = 0, bad_frm = 0;
  int rdy_mode[2];
  int cyc = 0;
  logic [8:0] mon_hold;

  dvl_link #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .lnk_tx_clk(lnk_tx_clk), .lnk_tx_sym(lnk_tx_sym),
    .lnk_rx_clk(inj ? b_clk : lnk_tx_clk), .lnk_rx_sym(inj ? b_sym : lnk_tx_sym),
    .rx_err(rx_err)
  );

  always #(PER/2) clk = ~clk;

  function automatic logic [15:0] wfn(int v, int i);
    return 16'((v + 1) * 16'h3A01) ^ 16'(i * 16'h0107);
  endfunction
  function automatic logic [17:0] dfr(logic [15:0] d);
    return {1'b0, d[15:8], ^d, d[7:0]};
  endfunction
  function automatic logic [17:0] tfr(logic [7:0] c);
    return {1'b1, c, 1'b1, ~c};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sources: drive before the edge, note acceptance while inputs are stable
  always @(negedge clk) begin
    cyc++;
    for (int v = 0; v < 2; v++) begin
      src_valid[v] = (sent[v] < tgt[v]);
      src_data[v*16 +: 16] = wfn(v, sent[v]);
    end
    case (rdy_mode[0])
      0: snk_ready[0] = 1'b0;
      1: snk_ready[0] = 1'b1;
      default: snk_ready[0] = ((cyc * 7) % 5) < 2;
    endcase
    case (rdy_mode[1])
      0: snk_ready[1] = 1'b0;
      1: snk_ready[1] = 1'b1;
      default: snk_ready[1] = ((cyc * 3) % 7) < 3;
    endcase
    #1;
    if (rst_n) begin
      for (int v = 0; v < 2; v++) begin
        if (src_valid[v] && src_ready[v]) sent[v]++;
        if (snk_valid[v] && snk_ready[v]) begin
          // R9 R6 R3: in-order, correct channel, correct payload
          chk(snk_data[v*16 +: 16] == wfn(v, rcv[v]), v ? "R9 vc1 word" : "R9 vc0 word",
              snk_data[v*16 +: 16], wfn(v, rcv[v]));
          rcv[v]++;
        end
      end
      if (rx_err) err_cnt++;
      // link monitor, R3 R4: every transmitted frame is a valid code word
      if (!lnk_tx_clk) mon_hold = lnk_tx_sym;
      else begin
        logic [17:0] f;
        f = {mon_hold, lnk_tx_sym};
        if (!((!f[17] && !(^f)) || f == tfr(8'h3C) || f == tfr(8'h5A) ||
              f == tfr(8'hA5) || f == tfr(8'h96) || f == tfr(8'h69))) bad_frm++;
      end
    end
  end

  task automatic wait_done(input int lim);
    for (int k = 0; k < lim; k++) begin
      if (rcv[0] == tgt[0] && rcv[1] == tgt[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [17:0] f);
    @(negedge clk);
    inj = 1'b1; b_clk = 1'b0; b_sym = f[17:9];
    @(negedge clk);
    b_clk = 1'b1; b_sym = f[8:0];
  endtask

  task automatic flip_sweep(input logic [17:0] f, input string req);
    for (int b = 0; b < 18; b++) begin
      int e0, r0, r1;
      e0 = err_cnt; r0 = rcv[0]; r1 = rcv[1];
      send_frame(f ^ (18'd1 << b));
      send_frame(tfr(8'h3C));
      send_frame(tfr(8'h3C));
      chk(err_cnt == e0 + 1, req, err_cnt - e0, 1);
      chk(rcv[0] == r0 && rcv[1] == r1 && snk_valid == 2'b00, req, snk_valid, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; inj = 1'b0; b_clk = 1'b0; b_sym = '0;
    for (int v = 0; v < 2; v++) begin sent[v] = 0; tgt[v] = 0; rcv[v] = 0; rdy_mode[v] = 1; end
    src_valid = '0; src_data = '0; snk_ready = '0;
    repeat (4) @(negedge clk);
    #2;
    // R1: reset state
    chk(lnk_tx_sym == 9'h13C, "R1 idle symbol", lnk_tx_sym, 9'h13C);
    chk(lnk_tx_clk == 1'b0, "R1 fclk low", lnk_tx_clk, 0);
    chk(src_ready == 2'b00 && snk_valid == 2'b00, "R1 handshakes low", {src_ready, snk_valid}, 0);
    chk(rx_err == 1'b0, "R1 no error", rx_err, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: forwarded clock alternates
    begin
      logic p;
      p = lnk_tx_clk;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #2;
        chk(lnk_tx_clk == ~p, "R2 fclk toggle", lnk_tx_clk, ~p);
        p = lnk_tx_clk;
      end
    end

    // both channels streaming, sinks always ready (R6 R8 R9)
    tgt[0] = 40; tgt[1] = 40;
    wait_done(3000);
    chk(rcv[0] == 40 && rcv[1] == 40, "R8 all words delivered", rcv[0] * 1000 + rcv[1], 40040);
    chk(bad_frm == 0, "R3 R4 transmitted frames valid", bad_frm, 0);

    // VC0 sink stalled: credit limit and no blocking of VC1 (R7 R9)
    rdy_mode[0] = 0;
    tgt[0] = 40 + 10; tgt[1] = 40 + 20;
    repeat (400) @(negedge clk);
    #2;
    chk(sent[0] == 40 + DEPTH, "R7 credit limit", sent[0] - 40, DEPTH);
    chk(rcv[0] == 40 && snk_valid[0], "R7 vc0 held", rcv[0], 40);
    chk(rcv[1] == 60, "R9 vc1 not blocked", rcv[1], 60);
    rdy_mode[0] = 1;
    wait_done(3000);
    chk(rcv[0] == 50, "R8 credits restored", rcv[0], 50);

    // irregular sink readiness on both channels
    rdy_mode[0] = 2; rdy_mode[1] = 2;
    tgt[0] = 90; tgt[1] = 100;
    wait_done(8000);
    chk(rcv[0] == 90 && rcv[1] == 100, "R9 throttled delivery", rcv[0] * 1000 + rcv[1], 90100);
    chk(bad_frm == 0, "R3 R4 frames valid under load", bad_frm, 0);
    rdy_mode[0] = 1; rdy_mode[1] = 1;
    repeat (60) @(negedge clk);

    // corruption sweep, link driven by the bench (R5)
    while (lnk_tx_clk !== 1'b1) @(negedge clk);
    send_frame(tfr(8'h3C));
    send_frame(tfr(8'h3C));
    chk(err_cnt == 0, "R5 idle accepted", err_cnt, 0);
    flip_sweep(tfr(8'h3C), "R5 idle flip");
    flip_sweep(tfr(8'h5A), "R5 sel0 flip");
    flip_sweep(tfr(8'hA5), "R5 sel1 flip");
    flip_sweep(tfr(8'h96), "R5 crd0 flip");
    flip_sweep(tfr(8'h69), "R5 crd1 flip");
    flip_sweep(dfr(16'h0000), "R5 data flip");
    flip_sweep(dfr(16'hFFFF), "R5 data flip");
    flip_sweep(dfr(16'hA5C3), "R5 data flip");

    // valid injected frames decode to the selected channel (R3 R6)
    begin
      int e0;
      e0 = err_cnt;
      send_frame(tfr(8'hA5));
      send_frame(dfr(wfn(1, rcv[1])));
      send_frame(tfr(8'h3C));
      send_frame(tfr(8'h3C));
      chk(rcv[1] == 101 && rcv[0] == 90, "R6 select vc1", rcv[1], 101);
      send_frame(tfr(8'h5A));
      send_frame(dfr(wfn(0, rcv[0])));
      send_frame(dfr(wfn(0, rcv[0] + 1)));
      send_frame(tfr(8'h3C));
      send_frame(tfr(8'h3C));
      chk(rcv[0] == 92 && rcv[1] == 101, "R3 R6 select vc0", rcv[0], 92);
      chk(err_cnt == e0, "R5 valid frames accepted", err_cnt - e0, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PER * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule